// File: doc/BRIEF.md
# Key Matrix Scanner with Debounce

This block walks a 16-column by 8-row key switch matrix one intersection at a time. A 7-bit scan address is held in a register. Its low four bits pick the single column line that is pulled low. Its high three bits pick which of the eight active-low row returns is sensed. The address advances by one after a programmable dwell, so the matrix settles before each sample, and it wraps from 127 back to 0.

When the sensed row reads pressed, the scanner stops on that address and starts a debounce timer. The timer length is set in clock cycles; at 125 MHz, ten milliseconds is 1,250,000 cycles. When the timer ends, the same intersection is sampled again:

- **Still pressed:** the address is published as a key code with a one-cycle valid pulse. The scanner then stays on that intersection until the key is released.
- **Not pressed:** the event is dropped, and scanning continues from the next address.

Top module: `keymatrix_scanner`

## Requirements
- R1: While reset is asserted, `col_drive_n` is 16'hFFFE (column 0 low, address 0), `key_valid` is 0 and `key_code` is 0.
- R2: In every cycle exactly one bit of `col_drive_n` is 0, and its index equals the low four bits of the current scan address.
- R3: The sense input is `row_n[addr[6:4]]`, active low. A key at row r and column c has address r*16+c. A report is only made while that row return reads low.
- R4: While no key is sensed, the scan address steps by +1 every STEP_CYCLES clocks. It wraps from 127 to 0, so the driven column moves to the next higher index, cyclically.
- R5: When the selected intersection reads pressed at the end of a dwell, the address is frozen. The column stays driven for DEBOUNCE_CYCLES clocks before the re-test.
- R6: If the re-test finds the intersection released, no `key_valid` is produced. Scanning resumes at the next address.
- R7: If the re-test finds it pressed, `key_valid` is high for exactly one cycle with `key_code` equal to the frozen address. `key_code` keeps that value until the next report.
- R8: After a report, the address stays frozen while the key is held. It advances on the first cycle the key reads released, so one press yields one code.
- R9: Keys at the extreme addresses 127 and 0 are found and reported across the wrap of the scan address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_n | input | 8 | Row return lines, low when a key on the driven column is down |
| col_drive_n | output | 16 | Column drive lines, one low at a time |
| key_code | output | 7 | Address of the last confirmed key, {row, column} |
| key_valid | output | 1 | One-cycle pulse marking a new key code |

## Verification
The matrix is modelled in the bench, so each test sets which intersections are closed and the row returns follow from the driven column.

- **Idle run:** with nothing pressed, the bench tells correct stepping and dwell timing apart from skipped or stalled addresses.
- **Steady presses:** held keys in the middle of the matrix and at addresses 127 and 0 separate a correct row/column split and wrap from a transposed or truncated address.
- **Long hold:** holding a key long after its report separates waiting for release from re-reporting.
- **Short press:** a key released after the scan has frozen on it separates a true re-test from reporting the first sample.

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner #(
  parameter int COL_BITS        = 4,
  parameter int ROW_BITS        = 3,
  parameter int STEP_CYCLES     = 4,
  parameter int DEBOUNCE_CYCLES = 1250000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [(1<<ROW_BITS)-1:0]     row_n,
  output logic [(1<<COL_BITS)-1:0]     col_drive_n,
  output logic [COL_BITS+ROW_BITS-1:0] key_code,
  output logic                         key_valid
);
  localparam int COLS   = 1 << COL_BITS;
  localparam int ADDR_W = COL_BITS + ROW_BITS;
  localparam int DB_W   = $clog2(DEBOUNCE_CYCLES + 1);
  localparam int ST_W   = $clog2(STEP_CYCLES + 1);

  typedef enum logic [1:0] {ST_SCAN, ST_BOUNCE, ST_HELD} state_t;

  state_t            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DB_W-1:0]   db_q;
  logic [ST_W-1:0]   dwell_q;

  logic sense, dwell_end, db_end;

  assign sense       = ~row_n[addr_q[ADDR_W-1:COL_BITS]];
  assign col_drive_n = ~(COLS'(1) << addr_q[COL_BITS-1:0]);
  assign dwell_end   = dwell_q == ST_W'(STEP_CYCLES - 1);
  assign db_end      = db_q == DB_W'(DEBOUNCE_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_SCAN;
      addr_q    <= '0;
      db_q      <= '0;
      dwell_q   <= '0;
      key_code  <= '0;
      key_valid <= 1'b0;
    end else begin
      key_valid <= 1'b0;
      case (state_q)
        ST_SCAN: begin
          if (dwell_end) begin
            dwell_q <= '0;
            if (sense) begin
              state_q <= ST_BOUNCE;
              db_q    <= '0;
            end else begin
              addr_q <= addr_q + 1'b1;
            end
          end else begin
            dwell_q <= dwell_q + 1'b1;
          end
        end
        ST_BOUNCE: begin
          if (db_end) begin
            if (sense) begin
              key_code  <= addr_q;
              key_valid <= 1'b1;
              state_q   <= ST_HELD;
            end else begin
              addr_q  <= addr_q + 1'b1;
              dwell_q <= '0;
              state_q <= ST_SCAN;
            end
          end else begin
            db_q <= db_q + 1'b1;
          end
        end
        ST_HELD: begin
          if (!sense) begin
            addr_q  <= addr_q + 1'b1;
            dwell_q <= '0;
            state_q <= ST_SCAN;
          end
        end
        default: state_q <= ST_SCAN;
      endcase
    end
  end
endmodule

// File: rtl/keymatrix_scanner_chk.sv
module keymatrix_scanner_chk #(
  parameter int COL_BITS = 4,
  parameter int ROW_BITS = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [(1<<ROW_BITS)-1:0]     row_n,
  input logic [(1<<COL_BITS)-1:0]     col_drive_n,
  input logic [COL_BITS+ROW_BITS-1:0] key_code,
  input logic                         key_valid
);
  localparam int COLS   = 1 << COL_BITS;
  localparam int ADDR_W = COL_BITS + ROW_BITS;

  AST_ONE_COLUMN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~col_drive_n) == 1); // R2

  AST_COLUMN_STEPS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (col_drive_n != $past(col_drive_n)) |->
      (col_drive_n == COLS'({$past(col_drive_n), $past(col_drive_n)} >> (COLS - 1)))); // R4

  AST_REPORT_ROW_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> !row_n[key_code[ADDR_W-1:COL_BITS]]); // R3

  AST_REPORT_COLUMN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> !col_drive_n[key_code[COL_BITS-1:0]]); // R5

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid); // R7

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> $stable(key_code)); // R7
endmodule

bind keymatrix_scanner keymatrix_scanner_chk #(
  .COL_BITS(COL_BITS),
  .ROW_BITS(ROW_BITS)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .row_n(row_n),
  .col_drive_n(col_drive_n),
  .key_code(key_code),
  .key_valid(key_valid)
);

// File: tb/tb_keymatrix_scanner.sv
`timescale 1ns/1ps
module tb_keymatrix_scanner;
  localparam int STEP = 2;
  localparam int DEB  = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  row_n;
  logic [15:0] col_drive_n;
  logic [6:0]  key_code;
  logic        key_valid;
  logic [7:0][15:0] pressed;

  int exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  int n_valid = 0;
  int popped;

  always #4 clk = ~clk;

  keymatrix_scanner #(.STEP_CYCLES(STEP), .DEBOUNCE_CYCLES(DEB)) dut (
    .clk(clk), .rst_n(rst_n), .row_n(row_n),
    .col_drive_n(col_drive_n), .key_code(key_code), .key_valid(key_valid));

  always_comb
    for (int r = 0; r < 8; r++) row_n[r] = ~|(pressed[r] & ~col_drive_n);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] col_of(input int addr);
    return ~(16'h1 << (addr % 16));
  endfunction

  always @(negedge clk) begin
    if (rst_n && key_valid) begin
      n_valid++;
      if (exp_q.size() == 0) chk(1'b0, "R6/R8 unexpected key_valid", key_code, -1);
      else begin
        popped = exp_q.pop_front();
        chk(key_code == 7'(popped), "R7 key_code at pulse", key_code, popped);
      end
    end
  end

  task automatic press_report(input int addr, input string tag);
    int t = 0;
    int bad = 0;
    exp_q.push_back(addr);
    pressed[addr / 16][addr % 16] = 1'b1;
    while (exp_q.size() != 0 && t < 1000) begin @(negedge clk); t++; end
    chk(t < 1000, {tag, " report arrives"}, t, 1000);
    chk(col_drive_n == col_of(addr), "R5 column frozen on key", col_drive_n, col_of(addr));
    repeat (300) begin
      @(negedge clk);
      if (col_drive_n != col_of(addr)) bad++;
    end
    chk(bad == 0, "R8 held key keeps scan frozen", bad, 0);
    pressed[addr / 16][addr % 16] = 1'b0;
    @(negedge clk);
    chk(col_drive_n == col_of(addr + 1), "R8 resume after release", col_drive_n, col_of(addr + 1));
  endtask

  task automatic bounce(input int addr);
    int run = 0;
    int t = 0;
    int k = 0;
    int v0;
    v0 = n_valid;
    pressed[addr / 16][addr % 16] = 1'b1;
    while (run < STEP + 2 && t < 1000) begin
      @(negedge clk);
      t++;
      if (col_drive_n == col_of(addr)) run++; else run = 0;
    end
    chk(t < 1000, "R5 scan freezes on sensed key", t, 1000);
    pressed[addr / 16][addr % 16] = 1'b0;
    while (col_drive_n == col_of(addr) && k < 200) begin @(negedge clk); k++; end
    chk(col_drive_n == col_of(addr + 1), "R6 resume at next address", col_drive_n, col_of(addr + 1));
    chk(run + k >= DEB, "R5 frozen for debounce interval", run + k, DEB);
    chk(n_valid == v0, "R6 no report for bounced key", n_valid, v0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int changes = 0;
    int bad_rot = 0;
    int bad_one = 0;
    logic [15:0] prev;
    pressed = '0;
    repeat (3) @(negedge clk);
    chk(col_drive_n == 16'hFFFE, "R1 reset column", col_drive_n, 16'hFFFE);
    chk(key_valid == 1'b0, "R1 reset valid", key_valid, 0);
    chk(key_code == 7'd0, "R1 reset code", key_code, 0);
    rst_n = 1'b1;
    prev = col_drive_n;
    repeat (80) begin
      @(negedge clk);
      if ($countones(~col_drive_n) != 1) bad_one++;
      if (col_drive_n != prev) begin
        changes++;
        if (col_drive_n != {prev[14:0], prev[15]}) bad_rot++;
      end
      prev = col_drive_n;
    end
    chk(bad_one == 0, "R2 one column low", bad_one, 0);
    chk(changes == 80 / STEP, "R4 step rate", changes, 80 / STEP);
    chk(bad_rot == 0, "R4 next column order", bad_rot, 0);

    press_report(8'h35, "R3 row 3 col 5");
    press_report(8'h7F, "R9 top address");
    press_report(8'h00, "R9 wrap to zero");
    bounce(8'h5A);
    chk(key_code == 7'h00, "R7 code held after bounce", key_code, 0);
    press_report(8'h5A, "R3 row 5 col 10");
    press_report(8'h5A, "R8 second press same key");
    chk(exp_q.size() == 0, "R7 all expected codes seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule